// File: doc/BRIEF.md
# Source-Routed Packet Steering Port

This block sits at one input of a packet router. A single upstream channel hands it flits, and the block steers each one to one of four downstream channels. Each channel carries one data word and three request wires: one for the header flit, one for an intermediate flit and one for the final flit. Exactly one of the three is raised per flit. Each channel also has one acknowledge wire. Transfers follow a four-phase handshake: the request rises, the acknowledge rises, the request falls, and then the acknowledge falls.

Routing is decided by the sender. The top two bits of a header word name the downstream channel. The block stores them and uses them for every later flit of the same packet. Before the header leaves, its word is rotated left by two positions, so the next hop finds its own direction in the top bits. Intermediate and final words pass unchanged.

The handshake is modelled with a clock. Forwarded requests, the data word and the upstream acknowledge come from registers, and each step of the handshake takes one clock cycle to pass through the block. A flit that arrives with no open packet, or with more than one request wire raised, is flagged as a protocol error. Such a flit is not forwarded, and the block acknowledges it itself.

Top module: `flit_steer_port`

## Requirements
- R1: After a synchronous reset, all forwarded request wires, `in_ack` and `proto_err` are low, and no packet is open.
- R2: A header request sampled while idle raises `out_hdr[d]` one cycle later, where d is the value of `in_data[DATA_W-1:DATA_W-2]` (channel index 0 to 3).
- R3: The forwarded header word equals the input word rotated left by two bits, that is `{in_data[DATA_W-3:0], in_data[DATA_W-1:DATA_W-2]}`.
- R4: Intermediate and final flits go out on `out_mid[d]` or `out_end[d]`, where d is the direction stored from the last header. Their word is unchanged, whatever their own top bits hold.
- R5: Only the selected channel carries a request. At any time at most one bit of `{out_hdr, out_mid, out_end}` is high.
- R6: `in_ack` rises one cycle after the selected channel's `out_ack` is seen high, and falls one cycle after it is seen low again. An acknowledge on any other channel has no effect.
- R7: `out_data` and the selected channel stay constant from the cycle the request is forwarded until the downstream acknowledge has returned low.
- R8: The forwarded request falls one cycle after the upstream request is seen low, which can only happen after `in_ack` has risen.
- R9: An intermediate or final flit that arrives with no open packet (after reset, or after a final flit has completed) is not forwarded. In that case `proto_err` and `in_ack` rise one cycle later and both fall one cycle after the request drops.
- R10: A flit with more than one request wire high is handled as the protocol error of R9.
- R11: A header that arrives while a packet is open stores a new direction, and later flits follow that new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hdr | input | 1 | Upstream header-flit request |
| in_mid | input | 1 | Upstream intermediate-flit request |
| in_end | input | 1 | Upstream final-flit request |
| in_data | input | DATA_W | Upstream flit word |
| in_ack | output | 1 | Acknowledge returned upstream |
| out_hdr | output | NUM_OUT | Header request, one bit per downstream channel |
| out_mid | output | NUM_OUT | Intermediate request, one bit per downstream channel |
| out_end | output | NUM_OUT | Final request, one bit per downstream channel |
| out_data | output | DATA_W | Flit word, shared by all downstream channels |
| out_ack | input | NUM_OUT | Acknowledge from each downstream channel |
| proto_err | output | 1 | High while an illegal flit is being absorbed |

## Verification
Two situations are hard to reach from the ports. The first is a flit that must follow the stored direction even though its own top bits point somewhere else. The second is an acknowledge arriving on the wrong channel in the middle of a handshake. The bench sweeps every pair of direction and next-hop bits in the header. It sends intermediate words whose top bits are the inverse of the stored direction, and during each header handshake it raises a stray acknowledge on a neighbouring channel before the true one. The error paths are reached by sending an intermediate flit straight after reset, again after a final flit, and with two request wires high together. A second header is also sent in the middle of a packet.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  // One-hot flit kind as carried on the three request wires
  typedef struct packed {
    logic hdr;
    logic mid;
    logic fin;
  } fkind_t;

  // Clocked four-phase handshake progress
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,   // waiting for an upstream request
    ST_REQ  = 3'd1,   // request forwarded, waiting for downstream ack
    ST_ACK  = 3'd2,   // ack returned upstream, waiting for request to drop
    ST_RTZ  = 3'd3,   // request dropped, waiting for downstream ack to drop
    ST_ERR  = 3'd4    // absorbing an illegal flit
  } hs_state_t;

endpackage

// File: rtl/fsp_flit_decode.sv
module fsp_flit_decode
  import fsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIR_W  = 2
) (
  input  logic              req_hdr,
  input  logic              req_mid,
  input  logic              req_end,
  input  logic [DATA_W-1:0] data,
  output logic              any_req,
  output logic              kind_ok,
  output fkind_t            kind,
  output logic [DIR_W-1:0]  hdr_dir,
  output logic [DATA_W-1:0] rot_data
);

  always_comb begin
    kind.hdr = req_hdr;
    kind.mid = req_mid;
    kind.fin = req_end;
    any_req  = req_hdr | req_mid | req_end;
    kind_ok  = (req_hdr & ~req_mid & ~req_end) |
               (~req_hdr & req_mid & ~req_end) |
               (~req_hdr & ~req_mid & req_end);
  end

  // Direction lives in the top bits of the header word
  assign hdr_dir  = data[DATA_W-1 -: DIR_W];
  // Rotate left so the next hop's direction reaches the top
  assign rot_data = {data[DATA_W-DIR_W-1:0], data[DATA_W-1 -: DIR_W]};

endmodule

// File: rtl/fsp_route_latch.sv
module fsp_route_latch #(
  parameter int DIR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             release_pkt,
  input  logic [DIR_W-1:0] dir_in,
  output logic [DIR_W-1:0] dir_q,
  output logic             open_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      open_q <= 1'b0;
    end else if (capture) begin
      dir_q  <= dir_in;
      open_q <= 1'b1;
    end else if (release_pkt) begin
      open_q <= 1'b0;
    end
  end

endmodule

// File: rtl/fsp_hs_ctrl.sv
module fsp_hs_ctrl
  import fsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_req,
  input  logic              kind_ok,
  input  fkind_t            kind,
  input  logic [DIR_W-1:0]  hdr_dir,
  input  logic [DATA_W-1:0] rot_data,
  input  logic [DATA_W-1:0] plain_data,
  input  logic [DIR_W-1:0]  held_dir,
  input  logic              pkt_open,
  input  logic              ack_sel,
  output logic              fwd_q,
  output fkind_t            kind_q,
  output logic [DIR_W-1:0]  sel_q,
  output logic [DATA_W-1:0] data_q,
  output logic              in_ack_q,
  output logic              err_q,
  output logic              capture_hdr,
  output logic              release_pkt
);

  hs_state_t state_q;
  logic      idle_req;
  logic      start_ok;
  logic      start_bad;

  always_comb begin
    idle_req    = (state_q == ST_IDLE) && any_req;
    start_ok    = idle_req && kind_ok && (kind.hdr || pkt_open);
    start_bad   = idle_req && !start_ok;
    capture_hdr = start_ok && kind.hdr;
    release_pkt = start_ok && kind.fin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      fwd_q    <= 1'b0;
      kind_q   <= '0;
      sel_q    <= '0;
      data_q   <= '0;
      in_ack_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            fwd_q   <= 1'b1;
            kind_q  <= kind;
            sel_q   <= kind.hdr ? hdr_dir : held_dir;
            data_q  <= kind.hdr ? rot_data : plain_data;
            state_q <= ST_REQ;
          end else if (start_bad) begin
            err_q    <= 1'b1;
            in_ack_q <= 1'b1;
            state_q  <= ST_ERR;
          end
        end
        ST_REQ: begin
          if (ack_sel) begin
            in_ack_q <= 1'b1;
            state_q  <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (!any_req) begin
            fwd_q   <= 1'b0;
            state_q <= ST_RTZ;
          end
        end
        ST_RTZ: begin
          if (!ack_sel) begin
            in_ack_q <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        ST_ERR: begin
          if (!any_req) begin
            err_q    <= 1'b0;
            in_ack_q <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fsp_out_demux.sv
module fsp_out_demux
  import fsp_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int DIR_W   = 2
) (
  input  logic               fwd,
  input  fkind_t             kind,
  input  logic [DIR_W-1:0]   sel,
  input  logic [NUM_OUT-1:0] out_ack,
  output logic [NUM_OUT-1:0] out_hdr,
  output logic [NUM_OUT-1:0] out_mid,
  output logic [NUM_OUT-1:0] out_end,
  output logic               ack_sel
);

  logic [NUM_OUT-1:0] hit;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
    assign hit[i]     = (sel == DIR_W'(i));
    assign out_hdr[i] = fwd & hit[i] & kind.hdr;
    assign out_mid[i] = fwd & hit[i] & kind.mid;
    assign out_end[i] = fwd & hit[i] & kind.fin;
  end

  assign ack_sel = |(out_ack & hit);

endmodule

// File: rtl/flit_steer_port.sv
module flit_steer_port
  import fsp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_hdr,
  input  logic               in_mid,
  input  logic               in_end,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ack,
  output logic [NUM_OUT-1:0] out_hdr,
  output logic [NUM_OUT-1:0] out_mid,
  output logic [NUM_OUT-1:0] out_end,
  output logic [DATA_W-1:0]  out_data,
  input  logic [NUM_OUT-1:0] out_ack,
  output logic               proto_err
);

  localparam int DIR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  logic              any_req;
  logic              kind_ok;
  fkind_t            kind;
  logic [DIR_W-1:0]  hdr_dir;
  logic [DATA_W-1:0] rot_data;
  logic [DIR_W-1:0]  held_dir;
  logic              pkt_open;
  logic              capture_hdr;
  logic              release_pkt;
  logic              ack_sel;
  logic              fwd_q;
  fkind_t            kind_q;
  logic [DIR_W-1:0]  sel_q;

  fsp_flit_decode #(.DATA_W(DATA_W), .DIR_W(DIR_W)) u_dec (
    .req_hdr (in_hdr),
    .req_mid (in_mid),
    .req_end (in_end),
    .data    (in_data),
    .any_req (any_req),
    .kind_ok (kind_ok),
    .kind    (kind),
    .hdr_dir (hdr_dir),
    .rot_data(rot_data)
  );

  fsp_route_latch #(.DIR_W(DIR_W)) u_route (
    .clk        (clk),
    .rst        (rst),
    .capture    (capture_hdr),
    .release_pkt(release_pkt),
    .dir_in     (hdr_dir),
    .dir_q      (held_dir),
    .open_q     (pkt_open)
  );

  fsp_hs_ctrl #(.DATA_W(DATA_W), .DIR_W(DIR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .any_req    (any_req),
    .kind_ok    (kind_ok),
    .kind       (kind),
    .hdr_dir    (hdr_dir),
    .rot_data   (rot_data),
    .plain_data (in_data),
    .held_dir   (held_dir),
    .pkt_open   (pkt_open),
    .ack_sel    (ack_sel),
    .fwd_q      (fwd_q),
    .kind_q     (kind_q),
    .sel_q      (sel_q),
    .data_q     (out_data),
    .in_ack_q   (in_ack),
    .err_q      (proto_err),
    .capture_hdr(capture_hdr),
    .release_pkt(release_pkt)
  );

  fsp_out_demux #(.NUM_OUT(NUM_OUT), .DIR_W(DIR_W)) u_demux (
    .fwd    (fwd_q),
    .kind   (kind_q),
    .sel    (sel_q),
    .out_ack(out_ack),
    .out_hdr(out_hdr),
    .out_mid(out_mid),
    .out_end(out_end),
    .ack_sel(ack_sel)
  );

endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int DATA_W  = 32,
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [DATA_W-1:0]  in_data,
  input logic               in_ack,
  input logic [NUM_OUT-1:0] out_hdr,
  input logic [NUM_OUT-1:0] out_mid,
  input logic [NUM_OUT-1:0] out_end,
  input logic [DATA_W-1:0]  out_data,
  input logic [NUM_OUT-1:0] out_ack,
  input logic               proto_err
);

  localparam int DIR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  logic [3*NUM_OUT-1:0] reqs;
  assign reqs = {out_hdr, out_mid, out_end};

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqs)); // R5

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    ((|reqs) && $past(|reqs)) |-> $stable(out_data)); // R7

  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_ack) && !proto_err) |-> $past(|out_ack)); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> (reqs == '0)); // R9

  AST_HDR_ROT: assert property (@(posedge clk) disable iff (rst)
    $rose(|out_hdr) |->
      (out_data == {$past(in_data[DATA_W-DIR_W-1:0]), $past(in_data[DATA_W-1 -: DIR_W])})); // R3

endmodule

bind flit_steer_port fsp_checker #(.DATA_W(DATA_W), .NUM_OUT(NUM_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_data  (in_data),
  .in_ack   (in_ack),
  .out_hdr  (out_hdr),
  .out_mid  (out_mid),
  .out_end  (out_end),
  .out_data (out_data),
  .out_ack  (out_ack),
  .proto_err(proto_err)
);

// File: tb/sim_flit_steer_port.sv
`timescale 1ns/1ps
module sim_flit_steer_port;

  localparam int W = 32;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_hdr = 0, in_mid = 0, in_end = 0;
  logic [W-1:0] in_data = '0;
  logic         in_ack;
  logic [N-1:0] out_hdr, out_mid, out_end;
  logic [W-1:0] out_data;
  logic [N-1:0] out_ack = '0;
  logic         proto_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  flit_steer_port #(.DATA_W(W), .NUM_OUT(N)) u0 (
    .clk(clk), .rst(rst),
    .in_hdr(in_hdr), .in_mid(in_mid), .in_end(in_end), .in_data(in_data),
    .in_ack(in_ack),
    .out_hdr(out_hdr), .out_mid(out_mid), .out_end(out_end), .out_data(out_data),
    .out_ack(out_ack), .proto_err(proto_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rotl2(input logic [W-1:0] d);
    return {d[W-3:0], d[W-1:W-2]};
  endfunction

  function automatic logic [11:0] req_vec(input int k, input int d);
    logic [11:0] v = '0;
    v[(2-k)*4 + d] = 1'b1;   // hdr bits 11:8, mid 7:4, end 3:0
    return v;
  endfunction

  // k: 0 header, 1 intermediate, 2 final
  task automatic send(input int k, input logic [W-1:0] d, input int dir, input string tag);
    logic [W-1:0] exp_d;
    exp_d = (k == 0) ? rotl2(d) : d;
    in_data = d;
    in_hdr = (k == 0); in_mid = (k == 1); in_end = (k == 2);
    @(negedge clk);
    chk({out_hdr,out_mid,out_end} == req_vec(k, dir), {tag, " R2 R4 R5 request route"},
        {52'd0, out_hdr, out_mid, out_end}, {52'd0, req_vec(k, dir)});
    chk(out_data == exp_d, (k == 0) ? {tag, " R3 rotated word"} : {tag, " R4 plain word"},
        64'(out_data), 64'(exp_d));
    chk(in_ack == 1'b0, {tag, " R6 no early ack"}, 64'(in_ack), 64'd0);
    out_ack[(dir + 1) % N] = 1'b1;
    @(negedge clk);
    chk(in_ack == 1'b0, {tag, " R6 foreign ack ignored"}, 64'(in_ack), 64'd0);
    out_ack = '0;
    out_ack[dir] = 1'b1;
    @(negedge clk);
    chk(in_ack == 1'b1, {tag, " R6 ack follows selected"}, 64'(in_ack), 64'd1);
    chk(out_data == exp_d, {tag, " R7 word held"}, 64'(out_data), 64'(exp_d));
    in_hdr = 0; in_mid = 0; in_end = 0;
    in_data = ~d;
    @(negedge clk);
    chk({out_hdr,out_mid,out_end} == 12'd0, {tag, " R8 request released"},
        {52'd0, out_hdr, out_mid, out_end}, 64'd0);
    chk(out_data == exp_d, {tag, " R7 word held in return"}, 64'(out_data), 64'(exp_d));
    out_ack = '0;
    @(negedge clk);
    chk(in_ack == 1'b0, {tag, " R6 ack drops"}, 64'(in_ack), 64'd0);
  endtask

  task automatic send_bad(input logic h, input logic m, input logic e, input string tag);
    in_data = 32'hC0DE_0001;
    in_hdr = h; in_mid = m; in_end = e;
    @(negedge clk);
    chk(proto_err == 1'b1, {tag, " error flagged"}, 64'(proto_err), 64'd1);
    chk(in_ack == 1'b1, {tag, " self ack"}, 64'(in_ack), 64'd1);
    chk({out_hdr,out_mid,out_end} == 12'd0, {tag, " not forwarded"},
        {52'd0, out_hdr, out_mid, out_end}, 64'd0);
    in_hdr = 0; in_mid = 0; in_end = 0;
    @(negedge clk);
    chk(proto_err == 1'b0 && in_ack == 1'b0, {tag, " error clears"},
        {62'd0, proto_err, in_ack}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({out_hdr,out_mid,out_end} == 12'd0 && in_ack == 0 && proto_err == 0,
        "R1 reset outputs", {51'd0, out_hdr, out_mid, out_end, in_ack}, 64'd0);
    send_bad(0, 1, 0, "R1 R9 mid after reset");
    send_bad(0, 0, 1, "R9 end after reset");

    for (int d = 0; d < N; d++) begin
      for (int nh = 0; nh < N; nh++) begin
        logic [W-1:0] hw;
        logic [W-1:0] mw;
        hw = {2'(d), 2'(nh), 28'(32'h0123457 * (d * 4 + nh + 1))};
        mw = {~2'(d), 30'(32'h1357_9BDF ^ (nh * 32'h0101_0101))};
        send(0, hw, d, "R2 header");
        send(1, mw, d, "R4 mid follows stored dir");
        send(1, ~mw ^ 32'h4000_0000, d, "R4 second mid");
        send(2, mw + 32'd7, d, "R4 end");
      end
    end

    send_bad(0, 1, 0, "R9 mid after end");
    send_bad(1, 1, 0, "R10 hdr+mid");
    send_bad(0, 1, 1, "R10 mid+end");

    send(0, 32'h4000_00F0, 1, "R11 first header");
    send(1, 32'hFFFF_0000, 1, "R11 mid on dir1");
    send(0, 32'hC123_4567, 3, "R11 second header");
    send(1, 32'h0000_AAAA, 3, "R11 mid on dir3");
    send(2, 32'h8000_0001, 3, "R11 end on dir3");
    send_bad(0, 0, 1, "R9 end after R11 packet");

    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    send_bad(0, 1, 0, "R1 packet closed after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule